// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a 24-bit periodic down-counter behind four 32-bit word registers, reached through a single-cycle read/write strobe interface. Software writes a reload value, clears the count, then sets the enable bit in the control word. From then on, every active tick decrements the count. When the count is zero, the next tick loads it from the reload register. Each pass from 1 to 0 sets a sticky wrap flag and, if interrupts are enabled, sends out a one-cycle interrupt pulse.

Ticks come from one of two sources. With the core source selected, every core clock cycle is a tick. With the reference source selected, the external reference input is synchronized through two flops and each rising edge becomes a tick. A read-only calibration word reports three constants fixed at build time: a tick count for a 10 ms period, a skew indication and an indication that the reference is absent.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0 and `irq` is low.
- R2: The word select is `bus_addr[3:2]`: 0 control, 1 reload, 2 current count, 3 calibration. A write to the calibration word has no effect on any register.
- R3: Control word layout: bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the tick source (1 core clock, 0 reference input), bit 16 is the wrap flag. All other bits read 0, and a write never changes the wrap flag.
- R4: The reload and count registers keep only write data bits 23:0, and bits 31:24 of both read 0.
- R5: While counting is enabled, a tick with count 0 loads the reload value and any other tick decrements the count by one. A reload value of N-1 therefore gives a period of N ticks.
- R6: While counting is disabled, the count holds its value.
- R7: A write of any data to the count register makes the count 0 and clears the wrap flag. This write wins over a tick in the same cycle.
- R8: The wrap flag sets on a tick that takes the count from 1 to 0. A read of the control word returns the flag and then clears it.
- R9: If a control read and a 1-to-0 tick happen in the same cycle, the flag stays set afterwards.
- R10: With reload value 0 and count 0, counting keeps the count at 0 and never sets the wrap flag or raises `irq`.
- R11: `irq` is high for exactly the one cycle after each 1-to-0 tick, and only if the interrupt enable was set when that tick occurred.
- R12: In reference mode, each rising edge of `ext_ref` gives exactly one tick, three clock edges after the edge is sampled. A level held high gives no further ticks.
- R13: The calibration word reads the 10 ms tick count in bits 23:0, the skew bit in bit 30 and the no-reference bit in bit 31, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_ref | input | 1 | Asynchronous reference tick input |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; marks the read for side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word, combinational |
| irq | output | 1 | Interrupt request pulse |

## Verification
A count that drifts by even one tick changes the readback of the current count on the next read, and it moves every later `irq` pulse by a whole cycle. That shift shows within one timer period. A wrong wrap flag shows at the next control read: either the value is missing or it appears twice. A lost or duplicated event when a read coincides with an underflow shows on the read that follows. A fault in the reference synchronizer shows as a count that stops, or that moves more than once for a single edge of `ext_ref`, within a few cycles of that edge.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int DW = 32,
  parameter int CW = 24,
  parameter logic [CW-1:0] CAL_TICKS = 24'h0F4240,
  parameter bit CAL_SKEW = 1'b1,
  parameter bit CAL_NOREF = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_ref,
  input  logic [3:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int PAD = DW - CW;
  localparam int FLAG_BIT = 16;

  logic          en_q, ie_q, core_q, wrap_q, irq_q;
  logic [CW-1:0] reload_q, count_q;
  logic [2:0]    sync_q;
  logic          tick, ref_edge, step, underflow;
  logic          sel_ctl, sel_rld, sel_cnt;
  logic [DW-1:0] ctl_word;
  logic          unused_bits;

  assign sel_ctl = bus_addr[3:2] == 2'd0;
  assign sel_rld = bus_addr[3:2] == 2'd1;
  assign sel_cnt = bus_addr[3:2] == 2'd2;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:CW]};

  assign ref_edge  = sync_q[1] & ~sync_q[2];
  assign tick      = core_q | ref_edge;
  assign step      = en_q & tick & ~(bus_wr & sel_cnt);
  assign underflow = step & (count_q == {{(CW-1){1'b0}}, 1'b1});
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_ref};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; core_q <= 1'b0;
      reload_q <= '0;
    end else if (bus_wr) begin
      if (sel_ctl) {core_q, ie_q, en_q} <= bus_wdata[2:0];
      if (sel_rld) reload_q <= bus_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                count_q <= '0;
    else if (bus_wr && sel_cnt) count_q <= '0;
    else if (step)             count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrap_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= underflow & ie_q;
      if (underflow)                                      wrap_q <= 1'b1;
      else if ((bus_wr && sel_cnt) || (bus_rd && sel_ctl)) wrap_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[0] = en_q;
    ctl_word[1] = ie_q;
    ctl_word[2] = core_q;
    ctl_word[FLAG_BIT] = wrap_q;
  end

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = ctl_word;
      2'd1:    bus_rdata = {{PAD{1'b0}}, reload_q};
      2'd2:    bus_rdata = {{PAD{1'b0}}, count_q};
      default: bus_rdata = {CAL_NOREF, CAL_SKEW, {(PAD-2){1'b0}}, CAL_TICKS};
    endcase
  end

  p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(bus_wr && sel_cnt)) |=> $stable(count_q));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_cnt) |=> (count_q == '0 && !wrap_q));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> wrap_q);
  p_zero_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0 && count_q == '0) |=> (count_q == '0 && !irq_q));
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (count_q == '0 && $past(ie_q)) ##1 !irq_q);
  p_ref_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> !ref_edge);
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  localparam logic [23:0] TEN = 24'h0F4240;
  logic clk = 1'b0, rst_n = 1'b0, ext_ref = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, irq;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  logic m_en = 0, m_ie = 0, m_core = 0, m_wrap = 0, m_irq = 0;
  logic [23:0] m_rld = '0, m_cnt = '0;
  logic [2:0] m_sync = '0;

  always #2.5 clk = ~clk;

  tick_timer dut_i (.clk(clk), .rst_n(rst_n), .ext_ref(ext_ref), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a[3:2])
      2'd0: exp_read = {15'd0, m_wrap, 13'd0, m_core, m_ie, m_en};
      2'd1: exp_read = {8'd0, m_rld};
      2'd2: exp_read = {8'd0, m_cnt};
      default: exp_read = {1'b0, 1'b1, 6'd0, TEN};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge(logic wr, logic rd, logic [3:0] a, logic [31:0] d);
    logic tk, cw, st, uf;
    tk = m_core | (m_sync[1] & ~m_sync[2]);
    cw = wr && a[3:2] == 2'd2;
    st = m_en && tk && !cw;
    uf = st && m_cnt == 24'd1;
    m_irq = uf && m_ie;
    if (uf) m_wrap = 1'b1;
    else if (cw || (rd && a[3:2] == 2'd0)) m_wrap = 1'b0;
    if (cw) m_cnt = '0;
    else if (st) m_cnt = (m_cnt == '0) ? m_rld : m_cnt - 24'd1;
    if (wr && a[3:2] == 2'd0) {m_core, m_ie, m_en} = d[2:0];
    if (wr && a[3:2] == 2'd1) m_rld = d[23:0];
    m_sync = {m_sync[1:0], ext_ref};
  endtask

  task automatic step(logic wr, logic rd, logic [3:0] a, logic [31:0] d, string tag);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    if (rd) chk(tag, bus_rdata, exp_read(a));
    chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
    @(posedge clk);
    model_edge(wr, rd, a, d);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 4'h0, 32'd0, tag);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 4'h0, 0, "R1 reset ctrl");
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    step(0, 1, 4'hC, 0, "R13 calibration");
    step(1, 0, 4'hC, 32'hFFFF_FFFF, "R2 cal write");
    step(0, 1, 4'hC, 0, "R2 cal unchanged");
    step(0, 1, 4'h0, 0, "R2 ctrl unchanged");
    step(1, 0, 4'h4, 32'hAB00_0004, "R4");
    step(0, 1, 4'h4, 0, "R4 reload masked");
    step(1, 0, 4'h8, 32'hFFFF_FFFF, "R7");
    step(0, 1, 4'h8, 0, "R7 count zero");
    step(1, 0, 4'h0, 32'hFFFF_FFFF, "R3");
    step(0, 1, 4'h0, 0, "R3 ctrl bits");
    for (int i = 0; i < 12; i++) step(0, 1, 4'h8, 0, "R5 core count");
    step(0, 1, 4'h0, 0, "R8 flag read");
    step(0, 1, 4'h0, 0, "R8 flag cleared");
    step(1, 0, 4'h0, 32'h0001_0003, "R3 flag not writable");
    idle(4, "R11");
    step(1, 0, 4'h0, 32'h0, "R6");
    for (int i = 0; i < 5; i++) step(0, 1, 4'h8, 0, "R6 hold");
    // R9: reload 1, read control exactly on the 1-to-0 tick
    step(1, 0, 4'h4, 32'd1, "R9");
    step(1, 0, 4'h8, 32'd0, "R9");
    step(1, 0, 4'h0, 32'h7, "R9");
    while (m_cnt != 24'd1) step(0, 0, 4'h0, 0, "R9");
    step(0, 1, 4'h0, 0, "R9 coincident read");
    step(0, 1, 4'h0, 0, "R9 flag kept");
    // R7: count write wins over tick
    while (m_cnt != 24'd1) step(0, 0, 4'h0, 0, "R7");
    step(1, 0, 4'h8, 32'h55, "R7 write on underflow");
    step(0, 1, 4'h0, 0, "R7 no flag");
    // R10
    step(1, 0, 4'h4, 32'd0, "R10");
    step(1, 0, 4'h8, 32'd0, "R10");
    for (int i = 0; i < 6; i++) step(0, 1, 4'h8, 0, "R10 stays zero");
    step(0, 1, 4'h0, 0, "R10 no flag");
    // R12: reference ticks, held high level
    step(1, 0, 4'h4, 32'd3, "R12");
    step(1, 0, 4'h0, 32'h3, "R12");
    for (int e = 0; e < 6; e++) begin
      ext_ref = 1'b1;
      for (int i = 0; i < 5; i++) step(0, 1, 4'h8, 0, "R12 ref count");
      ext_ref = 1'b0;
      for (int i = 0; i < 3; i++) step(0, 1, 4'h8, 0, "R12 ref count");
    end
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom % 10;
      logic [3:0] a = {$urandom_range(3, 0) [1:0], 2'b00};
      logic [31:0] d = $urandom;
      if ($urandom % 4 == 0) ext_ref = ~ext_ref;
      if (op < 2) begin
        if (a[3:2] == 2'd1 && ($urandom % 4 != 0)) d = $urandom % 8;
        if (a[3:2] == 2'd0 && ($urandom % 3 != 0)) d = d | 32'h1;
        if (a[3:2] == 2'd2 && ($urandom % 2 == 0)) a = 4'h4;
        step(1, 0, a, d, "R5 random write");
      end else if (op < 6) begin
        step(0, 1, a, 0, a[3:2] == 2'd0 ? "R8 random ctrl" : "R5 random read");
      end else begin
        step(0, 0, 4'h0, 0, "R11 random idle");
      end
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule